// File: doc/BRIEF.md
# Four-Plane Video Memory Read Path

This block serves host reads from a video memory organised as four parallel byte-wide planes. Each read strobe fetches the byte at the computed plane address from all four planes in the same clock. It keeps the four bytes in internal latches, which a separate write path later consumes. It then hands one byte back to the host.

Two read behaviours are available. In plane read mode the host gets the raw byte of one plane. With chain-4 addressing off, that plane comes from a 2-bit map select register. With chain-4 on, it comes from the two lowest host address bits. In compare mode the host gets a bitmap with one bit per pixel. A bit is set where the four plane bits of that pixel match a stored 4-bit colour, and a don't-care mask can drop individual planes from the test.

The plane memories are plain synchronous arrays. A simple fill port lets them be loaded.

Top module: `planar_read_path`

## Requirements
- R1: The mode input `rmode_cmp` comes from bit 3 of the graphics mode register. At 0 the returned byte is the raw byte of one plane. At 1 the returned byte is the colour-compare result.
- R2: With `chain4` low, the plane returned in plane read mode is `map_sel`. All four planes are read at plane address `host_addr`.
- R3: With `chain4` high, the plane returned in plane read mode is `host_addr[1:0]`. All four planes are read at plane address `host_addr >> 2`, with zeros shifted in at the top.
- R4: In compare mode, bit i of the result is 1 exactly when every plane p whose `cmp_care[p]` is 1 has bit i equal to `cmp_color[p]`. A plane with care bit 0 always matches, so `cmp_care = 0` yields 8'hFF.
- R5: Every read, in either mode, loads the four fetched plane bytes into the latches. `latch_bus[8p+7:8p]` holds plane p. The latches do not change in cycles without a read.
- R6: `rd_valid` is high for exactly the one cycle after each cycle with `rd_strobe` high. `rd_data` and `latch_bus` carry the new read result in that cycle. `rd_data` holds until the next read completes.
- R7: After reset, `rd_valid` is 0, `latch_bus` is all zeros and `rd_data` is 8'h00.
- R8: `rmode_cmp`, `map_sel`, `chain4`, `cmp_color` and `cmp_care` are sampled with the read strobe. Changing them between reads does not alter `rd_data`.
- R9: A fill with `fill_en` high writes `fill_data` at `fill_addr` into each plane whose `fill_planes` bit is 1. Other planes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Host read request, one cycle |
| host_addr | input | HADDR_W | Host byte address |
| rmode_cmp | input | 1 | Read mode: 0 plane byte, 1 colour compare |
| map_sel | input | 2 | Plane chosen for plane read mode when chain-4 is off |
| chain4 | input | 1 | Chain-4 addressing enable |
| cmp_color | input | 4 | Colour to compare against, bit p for plane p |
| cmp_care | input | 4 | Per-plane participation in the compare |
| fill_en | input | 1 | Memory fill strobe |
| fill_planes | input | 4 | Planes written by a fill |
| fill_addr | input | HADDR_W | Plane address for a fill |
| fill_data | input | 8 | Fill byte |
| rd_data | output | 8 | Byte returned to the host |
| rd_valid | output | 1 | rd_data is new this cycle |
| latch_bus | output | 32 | Four latched plane bytes, plane p at bits 8p+7:8p |

## Verification
A wrong latch byte shows on `latch_bus` in the `rd_valid` cycle of that read. It also reaches `rd_data` at once in plane mode, or as flipped pixel bits in compare mode. A wrong plane index or address shift shows up as a byte from the wrong plane or the wrong location, again in that same cycle. A bad capture of the sampled controls is seen on the next read, or as `rd_data` moving while the host changes its inputs between reads.

// File: rtl/plane_rd_pkg.sv
package plane_rd_pkg;
  localparam int NPLANES = 4;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 2;

  typedef logic [BYTE_W-1:0] pbyte_t;

  // Per-pixel compare: a pixel matches when each participating plane bit equals its colour bit.
  function automatic pbyte_t color_match(input logic [NPLANES*BYTE_W-1:0] planes,
                                         input logic [NPLANES-1:0] color,
                                         input logic [NPLANES-1:0] care);
    pbyte_t res;
    for (int i = 0; i < BYTE_W; i++) begin
      res[i] = 1'b1;
      for (int p = 0; p < NPLANES; p++) begin
        if (care[p] && (planes[p*BYTE_W+i] != color[p])) res[i] = 1'b0;
      end
    end
    return res;
  endfunction

  function automatic pbyte_t pick_plane(input logic [NPLANES*BYTE_W-1:0] planes,
                                        input logic [SEL_W-1:0] sel);
    return planes[sel*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/plane_mem.sv
module plane_mem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  // rdata is the plane's latch: it only moves on a read.
  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/plane_addr_sel.sv
module plane_addr_sel
  import plane_rd_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [AW-1:0]    host_addr,
  input  logic             chain4,
  input  logic [SEL_W-1:0] map_sel,
  output logic [AW-1:0]    plane_addr,
  output logic [SEL_W-1:0] plane_idx
);
  always_comb begin
    if (chain4) begin
      plane_addr = {{SEL_W{1'b0}}, host_addr[AW-1:SEL_W]};
      plane_idx  = host_addr[SEL_W-1:0];
    end else begin
      plane_addr = host_addr;
      plane_idx  = map_sel;
    end
  end
endmodule

// File: rtl/read_result.sv
module read_result
  import plane_rd_pkg::*;
(
  input  logic                      mode_cmp,
  input  logic [SEL_W-1:0]          sel,
  input  logic [NPLANES*BYTE_W-1:0] planes,
  input  logic [NPLANES-1:0]        color,
  input  logic [NPLANES-1:0]        care,
  output pbyte_t                    result
);
  pbyte_t plane_byte;
  pbyte_t cmp_byte;

  assign plane_byte = pick_plane(planes, sel);
  assign cmp_byte   = color_match(planes, color, care);
  assign result     = mode_cmp ? cmp_byte : plane_byte;
endmodule

// File: rtl/planar_read_path.sv
module planar_read_path
  import plane_rd_pkg::*;
#(
  parameter int HADDR_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_strobe,
  input  logic [HADDR_W-1:0]        host_addr,
  input  logic                      rmode_cmp,
  input  logic [1:0]                map_sel,
  input  logic                      chain4,
  input  logic [3:0]                cmp_color,
  input  logic [3:0]                cmp_care,
  input  logic                      fill_en,
  input  logic [3:0]                fill_planes,
  input  logic [HADDR_W-1:0]        fill_addr,
  input  logic [7:0]                fill_data,
  output logic [7:0]                rd_data,
  output logic                      rd_valid,
  output logic [31:0]               latch_bus
);
  localparam int LBUS_W = NPLANES * BYTE_W;

  // Named internal events for the checks
  logic                 rd_fire;
  logic [HADDR_W-1:0]   plane_addr;
  logic [SEL_W-1:0]     plane_idx;

  // Controls captured with the strobe
  logic                 mode_q;
  logic [SEL_W-1:0]     sel_q;
  logic [NPLANES-1:0]   color_q;
  logic [NPLANES-1:0]   care_q;

  logic [LBUS_W-1:0]    latches;

  assign rd_fire = rd_strobe;

  plane_addr_sel #(.AW(HADDR_W)) u_addr (
    .host_addr (host_addr),
    .chain4    (chain4),
    .map_sel   (map_sel),
    .plane_addr(plane_addr),
    .plane_idx (plane_idx)
  );

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    plane_mem #(.AW(HADDR_W), .DW(BYTE_W)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (fill_en & fill_planes[p]),
      .waddr(fill_addr),
      .wdata(fill_data),
      .re   (rd_fire),
      .raddr(plane_addr),
      .rdata(latches[p*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      mode_q   <= 1'b0;
      sel_q    <= '0;
      color_q  <= '0;
      care_q   <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        mode_q  <= rmode_cmp;
        sel_q   <= plane_idx;
        color_q <= cmp_color;
        care_q  <= cmp_care;
      end
    end
  end

  read_result u_res (
    .mode_cmp(mode_q),
    .sel     (sel_q),
    .planes  (latches),
    .color   (color_q),
    .care    (care_q),
    .result  (rd_data)
  );

  assign latch_bus = latches;

  // Assertions
  p_valid_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid);
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> !rd_valid);
  p_data_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));
  p_chain4_plane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && chain4) |=> (sel_q == $past(host_addr[1:0])));
  p_map_plane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !chain4) |=> (sel_q == $past(map_sel)));
  p_plane_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !mode_q) |-> (rd_data == latch_bus[sel_q*8 +: 8]));
  p_no_care_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && mode_q && care_q == 4'h0) |-> (rd_data == 8'hFF));
endmodule

// File: tb/planar_read_path_test.sv
module planar_read_path_test;
  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_strobe = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic rmode_cmp = 1'b0;
  logic [1:0] map_sel = '0;
  logic chain4 = 1'b0;
  logic [3:0] cmp_color = '0;
  logic [3:0] cmp_care = '0;
  logic fill_en = 1'b0;
  logic [3:0] fill_planes = '0;
  logic [AW-1:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [31:0] latch_bus;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [4][DEPTH];
  logic [7:0] last_data;

  always #4 clk = ~clk;

  planar_read_path #(.HADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .host_addr(host_addr),
    .rmode_cmp(rmode_cmp), .map_sel(map_sel), .chain4(chain4),
    .cmp_color(cmp_color), .cmp_care(cmp_care), .fill_en(fill_en),
    .fill_planes(fill_planes), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .latch_bus(latch_bus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int idx_of(input logic c4, input logic [1:0] ms, input logic [AW-1:0] a);
    return c4 ? int'(a % 4) : int'(ms);
  endfunction

  function automatic int loc_of(input logic c4, input logic [AW-1:0] a);
    return c4 ? int'(a / 4) : int'(a);
  endfunction

  // Count disagreeing planes per pixel; a pixel passes with zero disagreements.
  function automatic logic [7:0] exp_cmp(input int loc, input logic [3:0] col, input logic [3:0] cr);
    logic [7:0] r = '0;
    for (int b = 0; b < 8; b++) begin
      int miss = 0;
      for (int p = 0; p < 4; p++)
        if (cr[p] == 1'b1 && model[p][loc][b] != col[p]) miss++;
      r[b] = (miss == 0);
    end
    return r;
  endfunction

  task automatic fill(input logic [3:0] pl, input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    fill_en = 1'b1; fill_planes = pl; fill_addr = a; fill_data = d;
    for (int p = 0; p < 4; p++) if (pl[p]) model[p][a] = d;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a, input logic m, input logic [1:0] ms,
                         input logic c4, input logic [3:0] col, input logic [3:0] cr);
    int loc, ix;
    logic [7:0] e;
    logic [31:0] el;
    @(negedge clk);
    rd_strobe = 1'b1; host_addr = a; rmode_cmp = m; map_sel = ms; chain4 = c4;
    cmp_color = col; cmp_care = cr;
    @(negedge clk);
    rd_strobe = 1'b0;
    loc = loc_of(c4, a);
    ix = idx_of(c4, ms, a);
    el = {model[3][loc], model[2][loc], model[1][loc], model[0][loc]};
    e = m ? exp_cmp(loc, col, cr) : model[ix][loc];
    check({req, " valid"}, 32'(rd_valid), 32'd1);
    check({req, " data"}, 32'(rd_data), 32'(e));
    check({req, " R5 latches"}, latch_bus, el);
    last_data = rd_data;
  endtask

  initial begin : watchdog
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7 rd_valid", 32'(rd_valid), 32'd0);
    check("R7 latch_bus", latch_bus, 32'd0);
    check("R7 rd_data", 32'(rd_data), 32'd0);
    rst_n = 1'b1;

    // R9: fill every location of every plane, one plane at a time
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < DEPTH; a++)
        fill(4'(1 << p), AW'(a), 8'($urandom));
    // R9: multi-plane fill touches only the enabled planes
    fill(4'b0101, AW'(37), 8'hA5);
    do_read("R9 multi-plane fill", AW'(37), 1'b0, 2'd2, 1'b0, 4'h0, 4'h0);
    do_read("R9 untouched plane", AW'(37), 1'b0, 2'd1, 1'b0, 4'h0, 4'h0);

    // Directed: R2 every map select
    for (int s = 0; s < 4; s++)
      do_read("R2 map select", AW'(100 + s), 1'b0, 2'(s), 1'b0, 4'h0, 4'h0);
    // R3 chain-4 low bits pick plane, address shifted
    for (int s = 0; s < 4; s++)
      do_read("R3 chain4", AW'(DEPTH - 4 + s), 1'b0, 2'(3 - s), 1'b1, 4'h0, 4'h0);
    // R4 no care planes gives all ones
    do_read("R4 care none", AW'(5), 1'b1, 2'd0, 1'b0, 4'h9, 4'h0);
    // R4 known pattern
    fill(4'b1111, AW'(12), 8'h00);
    fill(4'b0001, AW'(12), 8'hF0);
    fill(4'b0100, AW'(12), 8'h3C);
    do_read("R4 pattern", AW'(12), 1'b1, 2'd0, 1'b0, 4'b0101, 4'b1111);
    check("R4 pattern value", 32'(rd_data), 32'h30);
    do_read("R4 care subset", AW'(12), 1'b1, 2'd0, 1'b0, 4'b0001, 4'b0011);
    check("R4 subset value", 32'(rd_data), 32'hF0);

    // R6 rd_valid lasts one cycle; R8 data held while inputs move
    @(negedge clk);
    check("R6 valid drops", 32'(rd_valid), 32'd0);
    rmode_cmp = 1'b0; map_sel = 2'd3; chain4 = 1'b1; cmp_color = 4'hF; cmp_care = 4'hF;
    host_addr = AW'(200);
    @(negedge clk);
    check("R8 data held", 32'(rd_data), 32'(last_data));
    check("R5 latches held", latch_bus,
          {model[3][12], model[2][12], model[1][12], model[0][12]});

    // R1 back-to-back reads switching mode
    do_read("R1 plane mode", AW'(77), 1'b0, 2'd1, 1'b0, 4'h3, 4'hF);
    do_read("R1 cmp mode", AW'(77), 1'b1, 2'd1, 1'b0, 4'h3, 4'hF);

    // Random reads
    for (int k = 0; k < 300; k++) begin
      logic c4 = 1'($urandom);
      logic m = 1'($urandom);
      do_read(m ? "R1 R4 random" : (c4 ? "R3 random" : "R2 random"),
              AW'($urandom), m, 2'($urandom), c4, 4'($urandom), 4'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule